// File: doc/BRIEF.md
# Transmit Clock Elastic Bit Buffer

This block sits on the serial transmit path, between the frame check generator and the transmit data pin. The internal transmit logic always produces one bit per period of a clock made by dividing the main clock. This block generates that divided clock and a one-cycle bit strobe that tells the upstream logic when each bit is taken. A mode bit chooses who owns the transmit clock pin. In driven mode the block puts the divided clock on the pin, and each bit goes straight to the data output. In external mode the pin is an input clocked by the transceiver. Bits then pass through a 16-entry single-bit elastic buffer. The buffer is written in the main clock domain and read on rising edges of the external clock.

The write and read pointers cross between the two domains in Gray code, each through a two-stage synchronizer. The reader stays idle, driving 0, until the buffer holds half its depth. This leaves the same room for drift in both directions. If the external rate is too slow, the buffer fills: the overflowing bit is dropped and the writer keeps dropping bits until the fill falls back to half. If the external rate is too fast, the buffer empties: the reader goes idle and restarts once half the depth has been refilled. Each fault sets its own sticky flag. A flag stays set until a clear strobe (a write of 1) removes it.

Top module: `txeb_top`

## Requirements
- R1: After reset the block is in external mode: `txClkOe` is 0, `txData` is 0 and both error flags are 0.
- R2: A `cfgWr` pulse loads `cfgExtClk` into the mode bit: 0 selects driven mode, and `txClkOe` is 1 from the next cycle; 1 selects external mode, and `txClkOe` is 0. In driven mode `txClkOut` is a square wave with a period of 2*HALF_PERIOD main clock cycles (8 by default).
- R3: In driven mode `txData` equals `txBitIn` combinationally, and no bit is written to the buffer: with `txClkIn` stopped, `overflowFlag` stays 0 however many strobes pass.
- R4: `wrStrobe` is high for exactly one main clock cycle in every divided clock period, in both modes.
- R5: In external mode, bits leave on `txData` in the order they were written, one bit per rising edge of `txClkIn`. Before the first bit is read, `txData` is 0. When the two rates match, neither flag is set.
- R6: The first bit is not read until at least DEPTH/2 (8) bits have been written.
- R7: In external mode, a strobe that arrives while DEPTH (16) bits are held sets `overflowFlag` at that clock edge. That bit is dropped and overwrites no stored bit, and `underflowFlag` is not affected.
- R8: In external mode, a read that finds the buffer empty after reading has started sets `underflowFlag`, and `overflowFlag` is not affected.
- R9: Each flag stays set until its clear strobe (`clrUnder` or `clrOver`) is 1 on a clock edge. That edge clears the flag, unless a new fault of the same kind arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| cfgWr | input | 1 | Load strobe for the mode bit |
| cfgExtClk | input | 1 | Mode value: 1 external clock input, 0 driven clock output |
| clrUnder | input | 1 | Clear strobe (write 1) for the underflow flag |
| clrOver | input | 1 | Clear strobe (write 1) for the overflow flag |
| txBitIn | input | 1 | Serial bit from the upstream generator |
| wrStrobe | output | 1 | One-cycle tick: `txBitIn` is taken at this edge |
| txClkIn | input | 1 | Transmit clock from the transceiver (external mode) |
| txClkOut | output | 1 | Divided transmit clock driven onto the pin |
| txClkOe | output | 1 | Output enable of the transmit clock pin |
| txData | output | 1 | Serial transmit data |
| underflowFlag | output | 1 | Sticky underflow flag |
| overflowFlag | output | 1 | Sticky overflow flag |

## Verification
In driven mode `txData` follows `txBitIn` with no register on the way, so the bench checks it a nanosecond after changing the input. The mode bit and the flag clears take effect at the first clock edge after their strobe, and the bench samples them at the falling edge after that one. The overflow flag is set at the same edge as the seventeenth strobe. The bench counts strobes one falling edge late, and so checks the flag when its count reaches 17, having confirmed that it is still clear at 16. The read side has synchronizer delay and is checked in bit order rather than by cycle: the bench records `txData` at every falling edge of `txClkIn`, aligns on a leading 1 marker bit, and compares the stream with the logged writes, so no check depends on the synchronizer latency.

// File: rtl/txeb_pkg.sv
`timescale 1ns/1ps
package txeb_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // store txBitIn at this edge
    logic extMode;  // 1: buffered path, 0: bypass
  } wrCtl_t;

  // fill status from datapath, all in the main clock domain
  typedef struct packed {
    logic full;        // DEPTH bits held
    logic atHalf;      // at most DEPTH/2 bits held
    logic underPulse;  // reader hit empty (one cycle)
  } fifoStat_t;
endpackage

// File: rtl/txeb_sync.sv
`timescale 1ns/1ps
module txeb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/txeb_datapath.sv
`timescale 1ns/1ps
module txeb_datapath
  import txeb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txClkIn,
  input  wrCtl_t    wrCtl,
  input  logic      txBitIn,
  output fifoStat_t fifoStat,
  output logic      txData
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write side, main clock ----------------
  logic [DEPTH-1:0] mem;
  logic [PW-1:0]    wrPtr, wrGray, rdGrayW, occW;
  logic             underTog, underSync, underSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mem    <= '0;
      wrPtr  <= '0;
      wrGray <= '0;
    end else if (wrCtl.wrEn) begin
      mem[wrPtr[AW-1:0]] <= txBitIn;
      wrPtr              <= wrPtr + PW'(1);
      wrGray             <= toGray(wrPtr + PW'(1));
    end
  end

  logic [PW-1:0] rdGray;

  txeb_sync #(.W(PW)) u_rdSync (.clk(clk), .rstN(rstN), .d(rdGray), .q(rdGrayW));
  txeb_sync #(.W(1))  u_unSync (.clk(clk), .rstN(rstN), .d(underTog), .q(underSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) underSeen <= 1'b0;
    else       underSeen <= underSync;
  end

  assign occW                = wrPtr - fromGray(rdGrayW);
  assign fifoStat.full       = (occW == PW'(DEPTH));
  assign fifoStat.atHalf     = (occW <= PW'(HALF));
  assign fifoStat.underPulse = underSync ^ underSeen;

  // ---------------- read side, external clock ----------------
  logic [PW-1:0] rdPtr, wrGrayR, occR;
  logic          started, rdBit, readNow;

  txeb_sync #(.W(PW)) u_wrSync (.clk(txClkIn), .rstN(rstN), .d(wrGray), .q(wrGrayR));

  always_comb begin
    occR    = fromGray(wrGrayR) - rdPtr;
    readNow = started ? (occR != '0) : (occR >= PW'(HALF));
  end

  always_ff @(posedge txClkIn or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      rdGray   <= '0;
      started  <= 1'b0;
      rdBit    <= 1'b0;
      underTog <= 1'b0;
    end else if (readNow) begin
      rdBit   <= mem[rdPtr[AW-1:0]];
      rdPtr   <= rdPtr + PW'(1);
      rdGray  <= toGray(rdPtr + PW'(1));
      started <= 1'b1;
    end else begin
      rdBit <= 1'b0;
      if (started) begin
        started  <= 1'b0;       // wait for refill to half depth
        underTog <= ~underTog;
      end
    end
  end

  assign txData = wrCtl.extMode ? rdBit : txBitIn;
endmodule

// File: rtl/txeb_ctrl.sv
`timescale 1ns/1ps
module txeb_ctrl
  import txeb_pkg::*;
#(
  parameter int HALF_PERIOD = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWr,
  input  logic      cfgExtClk,
  input  logic      clrUnder,
  input  logic      clrOver,
  input  fifoStat_t fifoStat,
  output wrCtl_t    wrCtl,
  output logic      wrStrobe,
  output logic      txClkOut,
  output logic      txClkOe,
  output logic      underflowFlag,
  output logic      overflowFlag
);
  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] divCnt;
  logic             divClk, extMode, dropping, tick, overEvt;

  // divider: bit tick on the edge where the divided clock falls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      divClk <= 1'b0;
    end else if (divCnt == LAST) begin
      divCnt <= '0;
      divClk <= ~divClk;
    end else begin
      divCnt <= divCnt + CNT_W'(1);
    end
  end

  assign tick    = (divCnt == LAST) && divClk;
  assign overEvt = tick && extMode && !dropping && fifoStat.full;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extMode       <= 1'b1;
      dropping      <= 1'b0;
      underflowFlag <= 1'b0;
      overflowFlag  <= 1'b0;
    end else begin
      if (cfgWr) extMode <= cfgExtClk;
      if (overEvt)                         dropping <= 1'b1;
      else if (dropping && fifoStat.atHalf) dropping <= 1'b0;
      overflowFlag  <= overEvt | (overflowFlag & ~clrOver);
      underflowFlag <= fifoStat.underPulse | (underflowFlag & ~clrUnder);
    end
  end

  assign wrCtl.wrEn    = tick && extMode && !dropping && !fifoStat.full;
  assign wrCtl.extMode = extMode;
  assign wrStrobe      = tick;
  assign txClkOut      = divClk;
  assign txClkOe       = !extMode;
endmodule

// File: rtl/txeb_top.sv
`timescale 1ns/1ps
module txeb_top
  import txeb_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int HALF_PERIOD = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWr,
  input  logic cfgExtClk,
  input  logic clrUnder,
  input  logic clrOver,
  input  logic txBitIn,
  output logic wrStrobe,
  input  logic txClkIn,
  output logic txClkOut,
  output logic txClkOe,
  output logic txData,
  output logic underflowFlag,
  output logic overflowFlag
);
  wrCtl_t    wrCtl;
  fifoStat_t fifoStat;

  txeb_ctrl #(.HALF_PERIOD(HALF_PERIOD)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgExtClk(cfgExtClk),
    .clrUnder(clrUnder), .clrOver(clrOver), .fifoStat(fifoStat),
    .wrCtl(wrCtl), .wrStrobe(wrStrobe), .txClkOut(txClkOut),
    .txClkOe(txClkOe), .underflowFlag(underflowFlag), .overflowFlag(overflowFlag)
  );

  txeb_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .txClkIn(txClkIn), .wrCtl(wrCtl),
    .txBitIn(txBitIn), .fifoStat(fifoStat), .txData(txData)
  );
endmodule

// File: rtl/txeb_checker.sv
`timescale 1ns/1ps
module txeb_checker
  import txeb_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      cfgWr,
  input logic      cfgExtClk,
  input logic      clrUnder,
  input logic      clrOver,
  input logic      txBitIn,
  input logic      wrStrobe,
  input logic      txClkOe,
  input logic      txData,
  input logic      underflowFlag,
  input logic      overflowFlag,
  input wrCtl_t    wrCtl,
  input fifoStat_t fifoStat
);
  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (txClkOe == !$past(cfgExtClk)));

  a_r3_bypass_data: assert property (@(posedge clk) disable iff (!rstN)
    txClkOe |-> (txData == txBitIn));

  a_r3_bypass_no_write: assert property (@(posedge clk) disable iff (!rstN)
    txClkOe |-> !wrCtl.wrEn);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  a_r7_full_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    fifoStat.full |-> !wrCtl.wrEn);

  a_r8_under_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    fifoStat.underPulse |=> underflowFlag);

  a_r9_over_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflowFlag && !clrOver) |=> overflowFlag);

  a_r9_under_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underflowFlag && !clrUnder) |=> underflowFlag);
endmodule

bind txeb_top txeb_checker u_chk (.*);

// File: tb/txeb_top_bench.sv
`timescale 1ns/1ps
module txeb_top_bench;
  logic clk = 1'b0, rstN = 1'b0, cfgWr = 1'b0, cfgExtClk = 1'b1;
  logic clrUnder = 1'b0, clrOver = 1'b0, txBitIn = 1'b0, txClkIn = 1'b0;
  logic wrStrobe, txClkOut, txClkOe, txData, underflowFlag, overflowFlag;

  int checks = 0, failures = 0;
  bit finished = 0;
  bit extRun = 0, logOn = 0, capOn = 0, sawStrobe = 0;
  int extHalf = 80;
  int wrIdx = 0, rdCnt = 0, firstOne = -1, wrAtFirst = 0;
  bit wrLog [1024];
  bit rdLog [512];

  txeb_top u_txeb_top (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgExtClk(cfgExtClk),
    .clrUnder(clrUnder), .clrOver(clrOver), .txBitIn(txBitIn),
    .wrStrobe(wrStrobe), .txClkIn(txClkIn), .txClkOut(txClkOut),
    .txClkOe(txClkOe), .txData(txData), .underflowFlag(underflowFlag),
    .overflowFlag(overflowFlag)
  );

  initial forever #10 clk = ~clk;

  // external transmit clock
  initial forever begin
    if (extRun) begin
      #(extHalf) txClkIn = 1'b1;
      #(extHalf) txClkIn = 1'b0;
    end else #1;
  end

  // upstream bit source: next bit after every strobe edge
  initial forever begin
    @(negedge clk);
    if (logOn) begin
      if (sawStrobe) begin
        wrIdx   = wrIdx + 1;
        txBitIn = wrLog[wrIdx % 1024];
      end
      sawStrobe = wrStrobe;
    end
  end

  // capture of the serial output at falling edges of the external clock
  initial forever begin
    @(negedge txClkIn);
    if (capOn && rdCnt < 512) begin
      rdLog[rdCnt] = txData;
      if (txData && firstOne < 0) begin
        firstOne  = rdCnt;
        wrAtFirst = wrIdx;
      end
      rdCnt = rdCnt + 1;
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic resetDut();
    extRun = 0; logOn = 0; capOn = 0;
    cfgWr = 0; clrUnder = 0; clrOver = 0;
    rstN = 0;
    steps(3);
    wrIdx = 0; sawStrobe = 0; txBitIn = wrLog[0];
    rdCnt = 0; firstOne = -1; wrAtFirst = 0;
    rstN = 1;
    step();
  endtask

  task automatic setMode(input bit ext);
    cfgWr = 1; cfgExtClk = ext;
    step();
    cfgWr = 0;
  endtask

  task automatic t_reset();
    resetDut();
    chk(txClkOe == 0, "R1 clock pin input after reset", txClkOe, 0);
    chk(txData == 0, "R1 data low after reset", txData, 0);
    chk(!underflowFlag && !overflowFlag, "R1 flags clear after reset",
        {underflowFlag, overflowFlag}, 0);
  endtask

  task automatic t_bypass();
    int r1 = -1, r2 = -1, nStrobe = 0;
    logic prev;
    resetDut();
    setMode(1'b0);
    chk(txClkOe == 1, "R2 driven mode enables pin", txClkOe, 1);
    prev = txClkOut;
    for (int i = 0; i < 40; i++) begin
      step();
      if (!prev && txClkOut) begin
        if (r1 < 0) r1 = i;
        else if (r2 < 0) r2 = i;
      end
      prev = txClkOut;
    end
    chk(r1 >= 0 && r2 - r1 == 8, "R2 divided clock period", r2 - r1, 8);
    for (int i = 0; i < 80; i++) begin
      step();
      if (wrStrobe) nStrobe++;
    end
    chk(nStrobe == 10, "R4 one strobe per divided period", nStrobe, 10);
    txBitIn = 1; #1;
    chk(txData == 1, "R3 bypass passes 1", txData, 1);
    txBitIn = 0; #1;
    chk(txData == 0, "R3 bypass passes 0", txData, 0);
    steps(400);
    chk(overflowFlag == 0, "R3 no buffer writes in driven mode", overflowFlag, 0);
    setMode(1'b1);
    chk(txClkOe == 0, "R2 external mode releases pin", txClkOe, 0);
  endtask

  task automatic t_matched();
    int bad = 0, zeros = 0, nStrobe = 0;
    resetDut();
    logOn = 1; capOn = 1; extHalf = 80; extRun = 1;
    for (int i = 0; i < 2200; i++) begin
      step();
      if (wrStrobe) nStrobe++;
    end
    extRun = 0; capOn = 0;
    chk(nStrobe == 275, "R4 strobe rate in external mode", nStrobe, 275);
    chk(firstOne >= 0 && rdCnt - firstOne >= 150, "R5 marker bit appears", firstOne, 0);
    for (int i = 0; i < firstOne && i < 512; i++) if (rdLog[i]) zeros++;
    chk(zeros == 0, "R5 idle zeros before first read", zeros, 0);
    for (int j = 0; j < 150; j++)
      if (firstOne >= 0 && rdLog[firstOne + j] != wrLog[j]) bad++;
    chk(bad == 0, "R5 output order equals write order", bad, 0);
    chk(wrAtFirst >= 8, "R6 reading waits for half depth", wrAtFirst, 8);
    chk(!underflowFlag && !overflowFlag, "R5 matched rates raise no flag",
        {underflowFlag, overflowFlag}, 0);
  endtask

  task automatic t_overflow();
    int bad = 0, guard = 0;
    resetDut();
    logOn = 1;
    while (wrIdx < 16) step();
    chk(overflowFlag == 0, "R7 no overflow with 16 held", overflowFlag, 0);
    while (wrIdx < 17) step();
    chk(overflowFlag == 1, "R7 overflow on 17th write", overflowFlag, 1);
    chk(underflowFlag == 0, "R7 underflow flag unaffected", underflowFlag, 0);
    steps(100);
    chk(overflowFlag == 1, "R9 overflow flag sticky", overflowFlag, 1);
    clrOver = 1; step(); clrOver = 0;
    chk(overflowFlag == 0, "R9 overflow clear", overflowFlag, 0);
    steps(50);
    chk(overflowFlag == 0, "R9 overflow stays clear", overflowFlag, 0);
    capOn = 1; extHalf = 80; extRun = 1;
    while ((firstOne < 0 || rdCnt < firstOne + 16) && guard < 2000) begin
      step();
      guard++;
    end
    extRun = 0; capOn = 0;
    for (int j = 0; j < 16; j++)
      if (firstOne < 0 || rdLog[firstOne + j] != wrLog[j]) bad++;
    chk(bad == 0, "R7 dropped bit overwrote nothing", bad, 0);
  endtask

  task automatic t_underflow();
    resetDut();
    logOn = 1; extHalf = 50; extRun = 1;
    steps(3000);
    chk(underflowFlag == 1, "R8 fast reader underflows", underflowFlag, 1);
    chk(overflowFlag == 0, "R8 overflow flag unaffected", overflowFlag, 0);
    extRun = 0;
    setMode(1'b0);
    steps(50);
    chk(underflowFlag == 1, "R9 underflow flag sticky", underflowFlag, 1);
    clrUnder = 1; step(); clrUnder = 0;
    chk(underflowFlag == 0, "R9 underflow clear", underflowFlag, 0);
    steps(50);
    chk(underflowFlag == 0, "R9 underflow stays clear", underflowFlag, 0);
  endtask

  initial begin
    logic [9:0] lfsr = 10'h2a5;
    for (int i = 0; i < 1024; i++) begin
      wrLog[i] = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[3], lfsr[9:1]};
    end
    wrLog[0] = 1'b1;  // marker for alignment
    t_reset();
    t_bypass();
    t_matched();
    t_overflow();
    t_underflow();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(190000 * 20);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule